// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block turns a set of 128 pending fast-interrupt lines into the address of the handler that should run next. The lines arrive as four 32-bit status words packed into one bus. Software programs a base address and a per-source stride. The block then keeps a 32-bit vector register that holds the base plus the stride times the index of the winning source. When no line is pending, the register holds all ones instead.

The vector register is reloaded on every clock cycle. An interrupt handler can therefore read it, service that source, and read it again to find the next lower-priority source that is still active. It stops when it reads the all-ones value. A small word-addressed register port gives access to the base, the stride and the vector. The vector cannot be written.

Top module: `irq_vector_gen`

## Requirements
- R1: While `rst_n` is low, and on the first read after reset, the base (address 0), the stride (address 1) and the vector (address 2) all read 0x00000000.
- R2: A write with `reg_wr` high to address 0 loads the base, and to address 1 loads the stride. Each value reads back on `reg_rdata` from the next cycle on.
- R3: Source i is bit i of `src_status`, so source 0 is bit 0 of the first 32-bit word and source 127 is bit 31 of the fourth word. When several sources are active, the lowest index wins.
- R4: With winning source i, the vector reads (base + stride * i) mod 2^32. Source 0 therefore gives the base itself, and source 127 gives base + 127 * stride. The value is the one computed from the inputs present at the previous rising edge.
- R5: When no source is active, the vector reads 0xFFFFFFFF.
- R6: A write to address 2 has no effect: the base, the stride and the vector read the same as they would without it.
- R7: The vector is recomputed every cycle. When the winning source clears, the next read shows the next active source with a higher index, or 0xFFFFFFFF if none remains.
- R8: Reads of address 3 return 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_status | input | 128 | Pending lines, four 32-bit status words, source i at bit i |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address: 0 base, 1 stride, 2 vector, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, available in the same cycle |

## Verification
The hardest case to reach from the ports is a dense pending set in which the winner sits at a high index: source 127 alone, or a lone bit in the fourth word with the stride near the top of its range so the sum wraps. Random 128-bit vectors almost never produce these patterns. The stimulus therefore builds pending sets word by word, leaving whole words empty at random, and adds directed single-bit patterns at indices 0, 31, 32, 127 and some random positions. It also walks a handler loop that clears the winning bit after each read until the all-ones value appears.

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_status,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STRIDE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(2);

  logic [DATA_W-1:0] base_q, stride_q, vec_q, vec_d;
  logic [IDX_W-1:0]  win_idx;
  logic              hit;

  always_comb begin
    win_idx = '0;
    hit     = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (src_status[i]) begin
        win_idx = IDX_W'(i);
        hit     = 1'b1;
      end
    end
  end

  assign vec_d = hit ? base_q + stride_q * {{(DATA_W-IDX_W){1'b0}}, win_idx} : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      vec_q    <= '0;
    end else begin
      vec_q <= vec_d;
      if (reg_wr && reg_addr == A_BASE)   base_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_STRIDE) stride_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_BASE:   reg_rdata = base_q;
      A_STRIDE: reg_rdata = stride_q;
      A_VEC:    reg_rdata = vec_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_gen_chk.sv
module irq_vector_gen_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_status,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  base_q,
  input logic [DATA_W-1:0]  stride_q,
  input logic [DATA_W-1:0]  vec_q
);
  // R5
  idle_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_status == '0) |=> (vec_q == '1));

  // R4
  src0_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_status[0] |=> (vec_q == $past(base_q)));

  // R2
  base_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> (base_q == $past(reg_wdata)));

  // R2
  stride_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> (stride_q == $past(reg_wdata)));

  // R6
  vec_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> ($stable(base_q) && $stable(stride_q)));

  // R4
  src127_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_status == {1'b1, {(NUM_SRC-1){1'b0}}}) |=>
      (vec_q == $past(base_q) + $past(stride_q) * DATA_W'(NUM_SRC - 1)));
endmodule

bind irq_vector_gen irq_vector_gen_chk #(
  .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_status(src_status),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .base_q(base_q), .stride_q(stride_q), .vec_q(vec_q)
);

// File: tb/irq_vector_gen_bench.sv
module irq_vector_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_status = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_base = '0, m_stride = '0;

  irq_vector_gen u_irq_vector_gen (
    .clk(clk), .rst_n(rst_n), .src_status(src_status), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [31:0] exp_vec(logic [127:0] s, logic [31:0] b, logic [31:0] st);
    for (int i = 0; i < 128; i++)
      if (s[i]) return b + st * 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int lowest(logic [127:0] s);
    for (int i = 0; i < 128; i++) if (s[i]) return i;
    return -1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_base = d;
    if (a == 2'd1) m_stride = d;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_vec(string req);
    logic [31:0] d;
    rd(2'd2, d);
    check(req, d, exp_vec(src_status, m_base, m_stride));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    src_status = {4{32'hA5A5_0001}};
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd0, d); check("R1 base in reset", d, 32'h0);
    rd(2'd1, d); check("R1 stride in reset", d, 32'h0);
    rd(2'd2, d); check("R1 vector in reset", d, 32'h0);
    rst_n = 1'b1;
    src_status = '0;
    rd(2'd2, d); check("R1 vector first read after reset", d, 32'h0);
    settle();
    check_vec("R5 nothing pending");
    rd(2'd3, d); check("R8 unused address", d, 32'h0);

    wr(2'd0, 32'h8000_1000); wr(2'd1, 32'h0000_0010);
    rd(2'd0, d); check("R2 base readback", d, 32'h8000_1000);
    rd(2'd1, d); check("R2 stride readback", d, 32'h0000_0010);

    foreach (src_status[i]) begin end
    src_status = '0; src_status[0] = 1'b1; settle(); check_vec("R4 source 0 gives base");
    src_status = '0; src_status[31] = 1'b1; settle(); check_vec("R3 source 31 word0 bit31");
    src_status = '0; src_status[32] = 1'b1; settle(); check_vec("R3 source 32 word1 bit0");
    src_status = '0; src_status[127] = 1'b1; settle(); check_vec("R4 source 127");
    src_status = '1; settle(); check_vec("R3 all pending lowest wins");

    wr(2'd1, 32'hFFFF_FFF0);
    src_status = '0; src_status[127] = 1'b1; settle();
    check_vec("R4 wraparound modulo 2^32");

    src_status = '0; src_status[5] = 1'b1; settle();
    wr(2'd2, 32'h1234_5678); settle();
    rd(2'd0, d); check("R6 base after vector write", d, m_base);
    rd(2'd1, d); check("R6 stride after vector write", d, m_stride);
    check_vec("R6 vector after vector write");

    src_status = '0;
    src_status[3] = 1'b1; src_status[64] = 1'b1; src_status[100] = 1'b1;
    wr(2'd1, 32'h0000_0100);
    settle();
    while (lowest(src_status) >= 0) begin
      check_vec("R7 handler loop");
      src_status[lowest(src_status)] = 1'b0;
      settle();
    end
    check_vec("R7 loop ends with sentinel");

    for (int k = 0; k < 300; k++) begin
      logic [127:0] s;
      int mode;
      if (k % 25 == 0) wr(2'($urandom_range(0, 1)), $urandom());
      mode = $urandom_range(0, 3);
      s = '0;
      if (mode == 0) s[$urandom_range(0, 127)] = 1'b1;
      else begin
        for (int w = 0; w < 4; w++)
          if ($urandom_range(0, 2) == 0) s[w*32 +: 32] = $urandom() & $urandom();
      end
      src_status = s;
      settle();
      check_vec(mode == 0 ? "R4 random single source" : "R3 random word mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule